// File: doc/BRIEF.md
# Reset Conditioner with Quarter-Rate Strobe

This block lets slow-update logic share one fast clock. It does not use a derived clock. It produces two outputs:

- **Conditioned reset.** The reset turns on at once, even with no clock edge, whenever the external reset request is active or the clock manager reports that it is not locked. It turns off only on a clock edge, after a short shift chain has flushed.
- **Enable strobe.** The strobe is high for one fast-clock cycle out of every four. Its phase is fixed by the release of reset.

A small register bank shows how the strobe is used. It captures its input only on cycles where the strobe is high, and it clears on any fast-clock edge that sees the reset active. This works because the fast clock keeps running during reset.

Use the block by feeding it the fast clock, the reset request and the lock flag. Then route the conditioned reset and the strobe to every register that should update at a quarter of the clock rate.

Top module: `qre_top`

## Requirements
- R1: `rst_o` goes to 1 as soon as `rst_req_i` is 1, with no clock edge needed. This also holds while the clock is stopped.
- R2: `rst_o` goes to 1 as soon as `lock_i` is 0, with no clock edge needed. This holds at any time, including mid-operation.
- R3: After `rst_req_i` is 0 and `lock_i` is 1, `rst_o` stays at 1 through the first rising edge and drops to 0 right after the second rising edge.
- R4: `en_o` is 0 in every instant where `rst_o` is 1.
- R5: Call the rising edge that drops `rst_o` edge 0. `en_o` is 1 only in the cycle between edge 3 and edge 4, and is 0 in the cycles after edges 1 and 2. This phase repeats after every reset release.
- R6: While reset stays off, `en_o` is high for exactly one cycle in every four, so consecutive pulses are four cycles apart.
- R7: `dout_o` takes the value of `din_i` at a rising edge only when `en_o` is 1 before that edge. At every other edge without reset, `dout_o` holds its value.
- R8: At any rising edge where `rst_o` is 1, `dout_o` becomes all zeros. This holds whatever the strobe state was before the reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast clock; the only clock for all registers |
| rst_req_i | input | 1 | Asynchronous reset request, active high |
| lock_i | input | 1 | Clock-manager lock flag, 1 = locked |
| din_i | input | LANES*DATA_W (16) | Data for the quarter-rate register bank |
| rst_o | output | 1 | Conditioned reset, active high |
| en_o | output | 1 | Quarter-rate enable strobe |
| dout_o | output | LANES*DATA_W (16) | Quarter-rate register bank contents |

## Verification
Suppose the strobe counter woke up in the wrong phase or at the wrong length. The first pulse after release would then appear on the wrong edge, and the bench sees that within four cycles. A shift chain that is too short or does not preset would make `rst_o` drop one edge early, or fail to rise while the clock is stopped. Both show on the first sampled edge after the stimulus. A bank that loads on a non-strobe edge, or that misses the clear, shows a wrong `dout_o` on the next sample, because the bench changes `din_i` on every cycle.

// File: rtl/qre_pkg.sv
package qre_pkg;
  localparam int unsigned DEF_RATIO  = 4;
  localparam int unsigned DEF_STAGES = 2;
  localparam int unsigned DEF_DATA_W = 8;
  localparam int unsigned DEF_LANES  = 2;

  function automatic int unsigned cnt_width(input int unsigned ratio);
    return (ratio < 2) ? 1 : $clog2(ratio);
  endfunction
endpackage

// File: rtl/qre_reset_chain.sv
module qre_reset_chain #(
  parameter int unsigned STAGES = qre_pkg::DEF_STAGES
) (
  input  logic clk_i,
  input  logic rst_req_i,
  input  logic lock_i,
  output logic rst_o
);
  logic             arst;
  logic [STAGES-1:0] chain_q;

  // lock loss counts as a reset request
  assign arst = rst_req_i | ~lock_i;

  always_ff @(posedge clk_i or posedge arst) begin
    if (arst) chain_q <= '1;
    else      chain_q <= {chain_q[STAGES-2:0], 1'b0};
  end

  assign rst_o = chain_q[STAGES-1];
endmodule

// File: rtl/qre_strobe_gen.sv
module qre_strobe_gen #(
  parameter int unsigned RATIO = qre_pkg::DEF_RATIO
) (
  input  logic clk_i,
  input  logic rst_i,
  output logic en_o
);
  localparam int unsigned CW = qre_pkg::cnt_width(RATIO);

  generate
    if (RATIO < 2) begin : g_full_rate
      assign en_o = ~rst_i;
    end else begin : g_divided
      localparam logic [CW-1:0] LAST   = CW'(RATIO - 1);
      localparam logic [CW-1:0] PRE_EN = CW'(RATIO - 2);
      logic [CW-1:0] cnt_q;
      logic          en_q;

      always_ff @(posedge clk_i) begin
        if (rst_i) begin
          cnt_q <= '0;
          en_q  <= 1'b0;
        end else begin
          cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
          en_q  <= (cnt_q == PRE_EN);
        end
      end

      // gated so the strobe drops as soon as reset asserts
      assign en_o = en_q & ~rst_i;
    end
  endgenerate
endmodule

// File: rtl/qre_gated_bank.sv
module qre_gated_bank #(
  parameter int unsigned DATA_W = qre_pkg::DEF_DATA_W,
  parameter int unsigned LANES  = qre_pkg::DEF_LANES
) (
  input  logic                    clk_i,
  input  logic                    rst_i,
  input  logic                    en_i,
  input  logic [LANES*DATA_W-1:0] d_i,
  output logic [LANES*DATA_W-1:0] q_o
);
  generate
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [DATA_W-1:0] r_q;
      always_ff @(posedge clk_i) begin
        if (rst_i)     r_q <= '0;
        else if (en_i) r_q <= d_i[l*DATA_W +: DATA_W];
      end
      assign q_o[l*DATA_W +: DATA_W] = r_q;
    end
  endgenerate
endmodule

// File: rtl/qre_top.sv
module qre_top #(
  parameter int unsigned RATIO  = qre_pkg::DEF_RATIO,
  parameter int unsigned STAGES = qre_pkg::DEF_STAGES,
  parameter int unsigned DATA_W = qre_pkg::DEF_DATA_W,
  parameter int unsigned LANES  = qre_pkg::DEF_LANES
) (
  input  logic                    clk_i,
  input  logic                    rst_req_i,
  input  logic                    lock_i,
  input  logic [LANES*DATA_W-1:0] din_i,
  output logic                    rst_o,
  output logic                    en_o,
  output logic [LANES*DATA_W-1:0] dout_o
);
  logic rst_c;
  logic en_c;

  qre_reset_chain #(.STAGES(STAGES)) u_rst (
    .clk_i(clk_i), .rst_req_i(rst_req_i), .lock_i(lock_i), .rst_o(rst_c)
  );

  qre_strobe_gen #(.RATIO(RATIO)) u_stb (
    .clk_i(clk_i), .rst_i(rst_c), .en_o(en_c)
  );

  qre_gated_bank #(.DATA_W(DATA_W), .LANES(LANES)) u_bank (
    .clk_i(clk_i), .rst_i(rst_c), .en_i(en_c), .d_i(din_i), .q_o(dout_o)
  );

  assign rst_o = rst_c;
  assign en_o  = en_c;
endmodule

// File: rtl/qre_checker.sv
module qre_checker #(
  parameter int unsigned DW = 16
) (
  input logic          clk_i,
  input logic          rst_req_i,
  input logic          lock_i,
  input logic          rst_o,
  input logic          en_o,
  input logic [DW-1:0] dout_o
);
  AST_REQ_FORCES_RESET: assert property (@(posedge clk_i) rst_req_i |-> rst_o); // R1
  AST_LOCK_LOSS_RESET: assert property (@(posedge clk_i) !lock_i |-> rst_o); // R2
  AST_RELEASE_TWO_EDGES: assert property (@(posedge clk_i)
    $fell(rst_o) |-> (!$past(rst_req_i, 1) && $past(lock_i, 1) &&
                      !$past(rst_req_i, 2) && $past(lock_i, 2))); // R3
  AST_NO_STROBE_IN_RESET: assert property (@(posedge clk_i) rst_o |-> !en_o); // R4
  AST_FIRST_PULSE_PHASE: assert property (@(posedge clk_i) disable iff (rst_o)
    $fell(rst_o) |-> !en_o ##1 !en_o ##1 !en_o ##1 en_o); // R5
  AST_STROBE_SPACING: assert property (@(posedge clk_i) disable iff (rst_o)
    en_o |=> !en_o ##1 !en_o ##1 !en_o ##1 en_o); // R6
  AST_BANK_HOLDS: assert property (@(posedge clk_i) disable iff (rst_o)
    !en_o |=> $stable(dout_o)); // R7
  AST_BANK_CLEARS: assert property (@(posedge clk_i) rst_o |=> (dout_o == '0)); // R8
endmodule

bind qre_top qre_checker #(.DW(LANES*DATA_W)) chk_i (
  .clk_i(clk_i), .rst_req_i(rst_req_i), .lock_i(lock_i),
  .rst_o(rst_o), .en_o(en_o), .dout_o(dout_o)
);

// File: tb/qre_top_tb_top.sv
module qre_top_tb_top;
  localparam int unsigned DW = 16;

  logic          clk = 1'b0;
  logic          clk_run = 1'b0;
  logic          rst_req = 1'b1;
  logic          lock = 1'b0;
  logic [DW-1:0] din = '0;
  logic          rst_o, en_o;
  logic [DW-1:0] dout;
  logic [DW-1:0] exp_d = '0;
  int            checks = 0;
  int            errors = 0;
  bit            done = 1'b0;

  always #4 if (clk_run) clk = ~clk;

  qre_top dut_i (
    .clk_i(clk), .rst_req_i(rst_req), .lock_i(lock), .din_i(din),
    .rst_o(rst_o), .en_o(en_o), .dout_o(dout)
  );

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cycle();
    @(posedge clk); @(negedge clk);
  endtask

  // R3: release takes exactly two edges after request removal with lock high
  task automatic release_and_run(input int n_cyc, input int seed);
    rst_req = 1'b0; lock = 1'b1;
    cycle();
    chk("R3 held after edge 1", rst_o, 1);
    chk("R4 strobe low in reset", en_o, 0);
    cycle();
    chk("R3 released after edge 2", rst_o, 0);
    exp_d = '0;
    for (int n = 1; n <= n_cyc; n++) begin
      logic en_now;
      din = DW'((n * 37 + seed) * 113);
      en_now = en_o;
      cycle();
      // R5/R6: strobe high only after edges 3, 7, 11, ...
      chk((n <= 4) ? "R5 first pulse phase" : "R6 strobe period",
          en_o, ((n % 4) == 3) ? 1 : 0);
      if (en_now) exp_d = din;
      chk("R7 bank load or hold", dout, exp_d);
    end
  endtask

  initial begin
    #1;
    chk("R1 reset with clock stopped", rst_o, 1);
    chk("R4 strobe low with clock stopped", en_o, 0);
    rst_req = 1'b0;
    #3;
    chk("R2 lock low keeps reset with clock stopped", rst_o, 1);
    rst_req = 1'b1;
    clk_run = 1'b1;
    din = 16'hA5A5;
    for (int i = 0; i < 3; i++) cycle();
    chk("R8 bank clear under reset", dout, 0);
    chk("R4 strobe low in reset", en_o, 0);

    release_and_run(21, 3);

    // lock loss mid-run while strobe is high
    while (en_o !== 1'b1) cycle();
    lock = 1'b0;
    #1;
    chk("R2 lock loss asserts reset", rst_o, 1);
    chk("R4 strobe dropped on lock loss", en_o, 0);
    cycle();
    chk("R8 bank cleared despite strobe", dout, 0);

    release_and_run(14, 9);

    // stop the clock, then request reset
    clk_run = 1'b0;
    #20;
    rst_req = 1'b1;
    #1;
    chk("R1 request with stopped clock", rst_o, 1);
    chk("R4 strobe low after request", en_o, 0);
    #10;
    clk_run = 1'b1;
    cycle();
    chk("R8 bank cleared after restart", dout, 0);
    cycle();

    release_and_run(17, 21);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule